// File: doc/BRIEF.md
# Flash Operation Completion Poller

This block works out when a parallel NOR flash device has finished an internal program or erase operation. It does this by reading the device's status byte over and over through a simple request/acknowledge read port. A controller gives it a one-cycle start pulse, a mode, the data byte that was written and a wait length. The poller then runs on its own until it sees the completion condition or reaches its iteration limit. When it stops, it gives a one-cycle done pulse and reports whether the run timed out or took longer than a set count.

The block has two detection modes. In toggle mode it takes one reference read and then compares status bit 6 of each later read with the read before it. The device is finished once that bit holds still. In data-polling mode it compares status bit 7 of each read with bit 7 of the expected data byte. Slow erase operations can add a wait of a programmable number of clock cycles before each comparison read in toggle mode.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `done_o`, `busy_o`, `rd_req_o`, `timeout_o` and `slow_o` are all 0.
- R2: In toggle mode (`mode_i`=0) the first read only sets the reference. The poll ends with done and no timeout on the first later read whose bit 6 equals bit 6 of the read just before it. Bits other than 6 have no effect.
- R3: In toggle mode, when a comparison read's bit 6 differs from the reference, that newest bit 6 becomes the reference for the next comparison. An equal bit 6 in two reads that are not consecutive does not end the poll.
- R4: In data-polling mode (`mode_i`=1) every read is a comparison read. The poll ends on the first read whose bit 7 equals bit 7 of `exp_data_i` as sampled at start. Bits 6..0 of both bytes have no effect.
- R5: If ITER_CAP comparison reads have been made without a match, the poll ends with `done_o` and with `timeout_o`=1. No further read is requested.
- R6: `slow_o` is 1 at done exactly when the number of comparison reads in that poll is greater than SLOW_LIMIT. Otherwise it is 0.
- R7: In toggle mode with a wait setting W>0, `rd_req_o` stays low for exactly W cycles before each comparison read. There is no wait before the reference read. In data-polling mode, and with W=0, reads follow one another back to back.
- R8: A start pulse while `busy_o` is 1 is ignored. The running poll's mode, count and result do not change.
- R9: `done_o` is high for exactly one cycle. `timeout_o` and `slow_o` keep their value until the next accepted start. The comparison count starts from zero on every accepted start.
- R10: `rd_req_o` stays high until a cycle with `rd_ack_i`=1. `rd_data_i` is taken in that cycle, and a non-acknowledged cycle moves the poll forward in no way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a poll |
| mode_i | input | 1 | 0 = toggle mode, 1 = data-polling mode |
| exp_data_i | input | 8 | Byte that was written; bit 7 is used in data-polling mode |
| wait_cycles_i | input | WAIT_W | Idle cycles before each toggle-mode comparison read |
| rd_req_o | output | 1 | Status read request |
| rd_ack_i | input | 1 | Read acknowledge; data valid in the same cycle |
| rd_data_i | input | 8 | Status byte returned by the device |
| busy_o | output | 1 | Poll in progress |
| done_o | output | 1 | One-cycle completion pulse |
| timeout_o | output | 1 | Last poll hit the iteration limit |
| slow_o | output | 1 | Last poll needed more than SLOW_LIMIT comparisons |

## Verification
Each result is due one cycle after the clock edge that takes the final acknowledged read. On that edge `done_o`, `timeout_o` and `slow_o` update together, and `busy_o` and `rd_req_o` drop. The bench drives inputs and samples outputs on the falling edge. It reads the result on the first falling edge where `done_o` is high and checks one falling edge later that the pulse has ended while the flags hold. Read counts come from the bench's own acknowledge responder. Wait timing is checked by counting falling edges where the block is busy with no request raised, and the expected value is W times the number of comparison reads.

// File: rtl/poll_pkg.sv
package poll_pkg;

    typedef enum logic {
        MODE_TOGGLE = 1'b0,
        MODE_DATA   = 1'b1
    } poll_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } poll_state_e;

    localparam int unsigned TOGGLE_BIT = 6;
    localparam int unsigned DATA_BIT   = 7;

endpackage

// File: rtl/poll_wait_timer.sv
module poll_wait_timer #(
    parameter int unsigned WAIT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [WAIT_W-1:0] load_val_i,
    input  logic              run_i,
    output logic              expired_o
);

    typedef struct packed {
        logic [WAIT_W-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load_i) begin
            tmr_d.cnt = load_val_i;
        end else if (run_i && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expired_o = (tmr_q.cnt == WAIT_W'(1));

    // R7
    wait_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (tmr_q.cnt != '0));

endmodule

// File: rtl/poll_iter_counter.sv
module poll_iter_counter #(
    parameter int unsigned CNT_W      = 28,
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned SLOW_LIMIT = 32'h0010_0000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             inc_i,
    output logic             last_o,
    output logic             slow_o
);

    localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(ITER_CAP - 1);
    localparam logic [CNT_W-1:0] SLOW_VAL = CNT_W'(SLOW_LIMIT);
    localparam logic [CNT_W-1:0] CAP_VAL  = CNT_W'(ITER_CAP);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } itc_t;

    itc_t itc_d, itc_q;

    always_comb begin
        itc_d = itc_q;
        if (clear_i) begin
            itc_d.cnt = '0;
        end else if (inc_i) begin
            itc_d.cnt = itc_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            itc_q <= '0;
        end else begin
            itc_q <= itc_d;
        end
    end

    // Flags describe the count as it will be after the current increment.
    assign last_o = (itc_q.cnt == LAST_VAL);
    assign slow_o = (itc_q.cnt >= SLOW_VAL);

    // R5
    cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        itc_q.cnt <= CAP_VAL);

endmodule

// File: rtl/poll_match.sv
module poll_match
    import poll_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  poll_mode_e        mode_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              ref_bit_i,
    input  logic              exp_bit_i,
    output logic              sample_o,
    output logic              match_o
);

    assign sample_o = data_i[TOGGLE_BIT];

    always_comb begin
        if (mode_i == MODE_TOGGLE) begin
            match_o = (data_i[TOGGLE_BIT] == ref_bit_i);
        end else begin
            match_o = (data_i[DATA_BIT] == exp_bit_i);
        end
    end

endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import poll_pkg::*;
#(
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned WAIT_W     = 16,
    parameter int unsigned CNT_W      = 28,
    parameter int unsigned ITER_CAP   = 32'h0FFF_FFFF,
    parameter int unsigned SLOW_LIMIT = 32'h0010_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              mode_i,
    input  logic [DATA_W-1:0] exp_data_i,
    input  logic [WAIT_W-1:0] wait_cycles_i,
    output logic              rd_req_o,
    input  logic              rd_ack_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic              slow_o
);

    typedef struct packed {
        poll_state_e       st;
        poll_mode_e        mode;
        logic              exp_bit;
        logic [WAIT_W-1:0] wait_cfg;
        logic              ref_valid;
        logic              ref_bit;
        logic              done;
        logic              timeout;
        logic              slow;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic tmr_load, tmr_run, tmr_expired;
    logic cnt_clear, cnt_inc, cnt_last, cnt_slow;
    logic rd_sample, rd_match;

    poll_wait_timer #(.WAIT_W(WAIT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (ctl_q.wait_cfg),
        .run_i      (tmr_run),
        .expired_o  (tmr_expired)
    );

    poll_iter_counter #(
        .CNT_W      (CNT_W),
        .ITER_CAP   (ITER_CAP),
        .SLOW_LIMIT (SLOW_LIMIT)
    ) u_count (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (cnt_clear),
        .inc_i   (cnt_inc),
        .last_o  (cnt_last),
        .slow_o  (cnt_slow)
    );

    poll_match #(.DATA_W(DATA_W)) u_match (
        .mode_i    (ctl_q.mode),
        .data_i    (rd_data_i),
        .ref_bit_i (ctl_q.ref_bit),
        .exp_bit_i (ctl_q.exp_bit),
        .sample_o  (rd_sample),
        .match_o   (rd_match)
    );

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_run   = 1'b0;
        cnt_clear = 1'b0;
        cnt_inc   = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    ctl_d.st        = ST_REQ;
                    ctl_d.mode      = poll_mode_e'(mode_i);
                    ctl_d.exp_bit   = exp_data_i[DATA_BIT];
                    ctl_d.wait_cfg  = wait_cycles_i;
                    ctl_d.ref_valid = 1'b0;
                    ctl_d.timeout   = 1'b0;
                    ctl_d.slow      = 1'b0;
                    cnt_clear       = 1'b1;
                end
            end
            ST_REQ: begin
                if (rd_ack_i) begin
                    if ((ctl_q.mode == MODE_TOGGLE) && !ctl_q.ref_valid) begin
                        ctl_d.ref_valid = 1'b1;
                        ctl_d.ref_bit   = rd_sample;
                        if (ctl_q.wait_cfg != '0) begin
                            ctl_d.st = ST_WAIT;
                            tmr_load = 1'b1;
                        end
                    end else begin
                        cnt_inc = 1'b1;
                        if (rd_match || cnt_last) begin
                            ctl_d.st      = ST_IDLE;
                            ctl_d.done    = 1'b1;
                            ctl_d.timeout = !rd_match;
                            ctl_d.slow    = cnt_slow;
                        end else begin
                            ctl_d.ref_bit = rd_sample;
                            if ((ctl_q.mode == MODE_TOGGLE) && (ctl_q.wait_cfg != '0)) begin
                                ctl_d.st = ST_WAIT;
                                tmr_load = 1'b1;
                            end
                        end
                    end
                end
            end
            ST_WAIT: begin
                tmr_run = 1'b1;
                if (tmr_expired) begin
                    ctl_d.st = ST_REQ;
                end
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, mode: MODE_TOGGLE, default: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign rd_req_o  = (ctl_q.st == ST_REQ);
    assign busy_o    = (ctl_q.st != ST_IDLE);
    assign done_o    = ctl_q.done;
    assign timeout_o = ctl_q.timeout;
    assign slow_o    = ctl_q.slow;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> rd_req_o);

    // R5
    timeout_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_o) |-> (done_o && !busy_o));

    // R6
    slow_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slow_o) |-> done_o);

    // R8
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (ctl_q.mode == $past(ctl_q.mode)));

endmodule

// File: tb/flash_done_poller_tb.sv
module flash_done_poller_tb_top;

    localparam int unsigned WAIT_W = 4;
    localparam int unsigned CAP    = 12;
    localparam int unsigned SLOWL  = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic       mode_i = 1'b0;
    logic [7:0] exp_data_i = 8'h00;
    logic [WAIT_W-1:0] wait_cycles_i = '0;
    logic       rd_req_o;
    logic       rd_ack_i = 1'b0;
    logic [7:0] rd_data_i = 8'h00;
    logic       busy_o, done_o, timeout_o, slow_o;

    int checks = 0;
    int errors = 0;

    logic [7:0] script [0:31];
    int rd_idx = 0;
    int ack_lag = 0;
    int lag_cnt = 0;

    always #2 clk = ~clk;

    flash_done_poller #(
        .DATA_W(8), .WAIT_W(WAIT_W), .CNT_W(28),
        .ITER_CAP(CAP), .SLOW_LIMIT(SLOWL)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i),
        .exp_data_i(exp_data_i), .wait_cycles_i(wait_cycles_i),
        .rd_req_o(rd_req_o), .rd_ack_i(rd_ack_i), .rd_data_i(rd_data_i),
        .busy_o(busy_o), .done_o(done_o), .timeout_o(timeout_o), .slow_o(slow_o)
    );

    // Read responder: answers a raised request after ack_lag idle cycles.
    always @(negedge clk) begin
        if (rd_req_o) begin
            if (lag_cnt >= ack_lag) begin
                rd_ack_i  = 1'b1;
                rd_data_i = script[(rd_idx < 32) ? rd_idx : 31];
                rd_idx    = rd_idx + 1;
                lag_cnt   = 0;
            end else begin
                rd_ack_i  = 1'b0;
                rd_data_i = 8'h5A;
                lag_cnt   = lag_cnt + 1;
            end
        end else begin
            rd_ack_i = 1'b0;
            lag_cnt  = 0;
        end
    end

    task automatic check_eq(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic fill(input logic [7:0] a, input logic [7:0] b);
        for (int i = 0; i < 32; i++) script[i] = (i % 2 == 0) ? a : b;
    endtask

    // Runs one poll; inject >= 0 pulses a second start in that busy cycle.
    task automatic run_poll(input logic md, input logic [7:0] ex, input int wt,
                            input int inject,
                            output int reads, output int low, output int busy_cyc,
                            output int to, output int sl);
        int n;
        logic seen;
        rd_idx = 0;
        low = 0; busy_cyc = 0; seen = 1'b0;
        @(negedge clk);
        start_i = 1'b1; mode_i = md; exp_data_i = ex; wait_cycles_i = WAIT_W'(wt);
        @(negedge clk);
        start_i = 1'b0;
        n = 0;
        while (!seen && n < 400) begin
            if (done_o) begin
                seen = 1'b1;
            end else begin
                if (busy_o) busy_cyc++;
                if (busy_o && !rd_req_o) low++;
                if (n == inject) begin
                    start_i = 1'b1; mode_i = ~md; exp_data_i = ~ex;
                end else begin
                    start_i = 1'b0;
                end
                @(negedge clk);
                n++;
            end
        end
        start_i = 1'b0;
        reads = rd_idx;
        check_eq("R9 done seen", int'(seen), 1);
        @(negedge clk);
        check_eq("R9 done single cycle", int'(done_o), 0);
        to = int'(timeout_o);
        sl = int'(slow_o);
    endtask

    task automatic t_reset();
        check_eq("R1 done", int'(done_o), 0);
        check_eq("R1 busy", int'(busy_o), 0);
        check_eq("R1 req", int'(rd_req_o), 0);
        check_eq("R1 timeout", int'(timeout_o), 0);
        check_eq("R1 slow", int'(slow_o), 0);
    endtask

    task automatic t_toggle();
        int r, l, b, to, sl;
        script[0] = 8'h4A; script[1] = 8'hC1;
        run_poll(1'b0, 8'h00, 0, -1, r, l, b, to, sl);
        check_eq("R2 reads stable", r, 2);
        check_eq("R2 no timeout", to, 0);
        check_eq("R7 no gaps wait0", l, 0);
        script[0] = 8'h3F; script[1] = 8'h40; script[2] = 8'hBF; script[3] = 8'h00;
        script[4] = 8'h40;
        run_poll(1'b0, 8'h00, 0, -1, r, l, b, to, sl);
        check_eq("R3 newest reference", r, 4);
        check_eq("R3 no timeout", to, 0);
    endtask

    task automatic t_data();
        int r, l, b, to, sl;
        script[0] = 8'h7F; script[1] = 8'h00; script[2] = 8'hFF;
        run_poll(1'b1, 8'h80, 3, -1, r, l, b, to, sl);
        check_eq("R4 reads bit7 match", r, 3);
        check_eq("R7 no wait in data mode", l, 0);
        script[0] = 8'h7F;
        run_poll(1'b1, 8'h35, 0, -1, r, l, b, to, sl);
        check_eq("R4 low bits ignored", r, 1);
        check_eq("R4 no timeout", to, 0);
    endtask

    task automatic t_slow();
        int r, l, b, to, sl;
        fill(8'h00, 8'h00); script[4] = 8'h80;
        run_poll(1'b1, 8'h80, 0, -1, r, l, b, to, sl);
        check_eq("R6 reads at limit", r, 5);
        check_eq("R6 not slow at limit", sl, 0);
        fill(8'h00, 8'h00); script[5] = 8'h80;
        run_poll(1'b1, 8'h80, 0, -1, r, l, b, to, sl);
        check_eq("R6 reads over limit", r, 6);
        check_eq("R6 slow over limit", sl, 1);
        check_eq("R6 no timeout", to, 0);
        check_eq("R9 slow held", int'(slow_o), 1);
        script[0] = 8'h80;
        run_poll(1'b1, 8'h80, 0, -1, r, l, b, to, sl);
        check_eq("R9 count cleared slow", sl, 0);
    endtask

    task automatic t_timeout();
        int r, l, b, to, sl;
        fill(8'h00, 8'h00);
        run_poll(1'b1, 8'h80, 0, -1, r, l, b, to, sl);
        check_eq("R5 data reads at cap", r, CAP);
        check_eq("R5 data timeout", to, 1);
        check_eq("R6 slow on timeout", sl, 1);
        check_eq("R5 no req after", int'(rd_req_o), 0);
        fill(8'h00, 8'h40);
        run_poll(1'b0, 8'h00, 0, -1, r, l, b, to, sl);
        check_eq("R5 toggle reads at cap", r, CAP + 1);
        check_eq("R5 toggle timeout", to, 1);
        script[0] = 8'h00; script[1] = 8'h00;
        run_poll(1'b0, 8'h00, 0, -1, r, l, b, to, sl);
        check_eq("R9 timeout cleared", to, 0);
    endtask

    task automatic t_wait();
        int r, l, b, to, sl;
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40;
        run_poll(1'b0, 8'h00, 3, -1, r, l, b, to, sl);
        check_eq("R7 reads", r, 3);
        check_eq("R7 gap cycles", l, 6);
        check_eq("R7 busy cycles", b, 9);
    endtask

    task automatic t_ignore();
        int r, l, b, to, sl;
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h00; script[3] = 8'h00;
        run_poll(1'b0, 8'h00, 2, 2, r, l, b, to, sl);
        check_eq("R8 reads unchanged", r, 4);
        check_eq("R8 gap cycles unchanged", l, 6);
        check_eq("R8 no timeout", to, 0);
        check_eq("R8 idle after", int'(busy_o), 0);
    endtask

    task automatic t_handshake();
        int r, l, b, to, sl;
        ack_lag = 2;
        script[0] = 8'h00; script[1] = 8'h40; script[2] = 8'h40;
        run_poll(1'b0, 8'h00, 0, -1, r, l, b, to, sl);
        ack_lag = 0;
        check_eq("R10 reads", r, 3);
        check_eq("R10 req held", l, 0);
        check_eq("R10 busy cycles", b, 9);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        fill(8'h00, 8'h00);
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_toggle();
        t_data();
        t_slow();
        t_timeout();
        t_wait();
        t_ignore();
        t_handshake();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule